// File: doc/BRIEF.md
# NMI Source Aggregation and Routing

This block collects four kinds of non-maskable interrupt event into one request for the processor. The events are a level from an internal system-error detector, a level from an upstream serial-IRQ decoder that reports an I/O-check condition, an asynchronous external NMI pin whose active edge can be chosen, and a software trigger written through the register port. Each event sets a sticky status bit. Each hardware source also has an enable bit that decides whether its status feeds the combined request.

The combined request normally leaves as a one-cycle pulse on `nmi_o`. That pulse is blocked while the global mask bit is set. The mask bit is bit 7 of the byte written at address 0x70. A redirect control sends the combined request to a level output `smi_o` instead. While the redirect is active, a separate status bit records each routed event. Software uses a small register port to program enables, clear status, set the mask and raise the software trigger. The port has a write strobe and a combinational read.

Top module: `nmi_router`

## Requirements
- R1: After reset, the control register (0x10) reads 0. The status register (0x11) reads 0. The mask register (0x70) reads 0x80, so the mask is set. Both `nmi_o` and `smi_o` are 0.
- R2: The mask register at 0x70 uses only data bit 7. While that bit is 1, `nmi_o` stays 0. While it is 0, NMI delivery is allowed. The other bits of that byte are ignored and read back as 0.
- R3: A high `serr_i` at a clock edge sets status bit 0, whatever the enables are. That status feeds the request only while control bit 0 is 1.
- R4: A high `iochk_i` at a clock edge sets status bit 1. That status feeds the request only while control bit 1 is 1.
- R5: `nmi_pin_i` passes through two synchronizer flops and then an edge detector. The detector looks for rising edges when control bit 3 is 0 and for falling edges when it is 1. Each transition of the selected polarity sets status bit 2 once, three edges after the pin changes. That status feeds the request only while control bit 2 is 1. Transitions of the other polarity are ignored.
- R6: Writing 1 to data bit 0 at address 0x12 sets status bit 3. That status always feeds the request. Reads of 0x12 return 0.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. If a set and a clear hit the same bit in the same cycle, the set wins. Status bits never clear by themselves.
- R8: `nmi_o` pulses high for exactly one cycle. It fires on the clock edge after the combined request becomes enabled, unmasked and not redirected. It fires again only after that condition has dropped and risen again.
- R9: While control bit 4 (redirect) is 1, `nmi_o` stays 0. In that state `smi_o` is a registered level that follows the combined request one cycle later, and the mask has no effect on it.
- R10: While the redirect is active and the combined request is present, status bit 4 is set. Status bit 4 is cleared by writing 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serr_i | input | 1 | Internal system-error event, active high |
| iochk_i | input | 1 | I/O-check event from the serial-IRQ decoder, active high |
| nmi_pin_i | input | 1 | Asynchronous external NMI pin |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | DATA_W | Combinational read data |
| nmi_o | output | 1 | One-cycle NMI pulse to the processor |
| smi_o | output | 1 | Redirected request level |

## Verification
The bench uses the default parameters: 8-bit address and data, two synchronizer stages, and registers at 0x10, 0x11, 0x12 and 0x70. With two stages, the pin-to-status latency is a fixed three edges, so directed checks can sample at exact cycles. The 8-bit data width puts the mask at bit 7, and the bench writes it with every other bit set. Random register traffic and random pin toggles also drive set-versus-clear collisions in the same cycle and polarity changes in the middle of a transition. A cycle model in the bench checks these against the outputs.

// File: rtl/nmi_router_pkg.sv
package nmi_router_pkg;

    localparam int SRC_SERR   = 0;
    localparam int SRC_IOCHK  = 1;
    localparam int SRC_PIN    = 2;
    localparam int SRC_SW     = 3;
    localparam int ST_SMI     = 4;
    localparam int NUM_HW_SRC = 3;
    localparam int NUM_ST     = 5;

    // packed order: redirect is bit 4, falling select bit 3, enables bits 2..0
    typedef struct packed {
        logic                  redir;
        logic                  pin_fall;
        logic [NUM_HW_SRC-1:0] en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t ctrl;
        logic  mask;
        logic  nmi_prev;
        logic  nmi;
        logic  smi;
    } state_t;

endpackage

// File: rtl/nmi_pin_edge.sv
module nmi_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic edge_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;
    logic               cur_lvl, old_lvl;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign cur_lvl = chain_q[SYNC_STAGES-1];
    assign old_lvl = chain_q[SYNC_STAGES];
    assign edge_o  = fall_sel_i ? (~cur_lvl & old_lvl) : (cur_lvl & ~old_lvl);

endmodule

// File: rtl/nmi_status_bank.sv
module nmi_status_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] st_o
);
    logic [N-1:0] st_d, st_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            if (set_i[i])      st_d[i] = 1'b1;
            else if (clr_i[i]) st_d[i] = 1'b0;
            else               st_d[i] = st_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st_o = st_q;

endmodule

// File: rtl/nmi_req_combine.sv
module nmi_req_combine #(
    parameter int N = 3
) (
    input  logic [N-1:0] hw_st_i,
    input  logic [N-1:0] en_i,
    input  logic         sw_st_i,
    output logic         req_o
);
    logic [N-1:0] gated;

    for (genvar i = 0; i < N; i++) begin : g_gate
        assign gated[i] = hw_st_i[i] & en_i[i];
    end

    assign req_o = (|gated) | sw_st_i;

endmodule

// File: rtl/nmi_router.sv
module nmi_router
    import nmi_router_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h10,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = 'h11,
    parameter logic [ADDR_W-1:0] SWTRIG_ADDR = 'h12,
    parameter logic [ADDR_W-1:0] MASK_ADDR   = 'h70,
    parameter int                MASK_BIT    = 7,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serr_i,
    input  logic              iochk_i,
    input  logic              nmi_pin_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              nmi_o,
    output logic              smi_o
);
    state_t              state_d, state_q;
    logic [NUM_ST-1:0]   st, st_set, st_clr;
    logic                pin_edge, req, nmi_req;
    logic                wr_ctrl, wr_stat, wr_sw, wr_mask;
    logic                mask_w, redir_w;
    logic [NUM_ST-1:0]   stat_w;
    logic                unused_bits;

    assign wr_ctrl = wr_en_i && (wr_addr_i == CTRL_ADDR);
    assign wr_stat = wr_en_i && (wr_addr_i == STAT_ADDR);
    assign wr_sw   = wr_en_i && (wr_addr_i == SWTRIG_ADDR);
    assign wr_mask = wr_en_i && (wr_addr_i == MASK_ADDR);
    assign unused_bits = ^wr_data_i;

    nmi_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (nmi_pin_i),
        .fall_sel_i (state_q.ctrl.pin_fall),
        .edge_o     (pin_edge)
    );

    nmi_req_combine #(.N(NUM_HW_SRC)) u_comb (
        .hw_st_i (st[NUM_HW_SRC-1:0]),
        .en_i    (state_q.ctrl.en),
        .sw_st_i (st[SRC_SW]),
        .req_o   (req)
    );

    always_comb begin
        st_set           = '0;
        st_set[SRC_SERR]  = serr_i;
        st_set[SRC_IOCHK] = iochk_i;
        st_set[SRC_PIN]   = pin_edge;
        st_set[SRC_SW]    = wr_sw & wr_data_i[0];
        st_set[ST_SMI]    = state_q.ctrl.redir & req;
        st_clr           = wr_stat ? wr_data_i[NUM_ST-1:0] : '0;
    end

    nmi_status_bank #(.N(NUM_ST)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (st_set),
        .clr_i (st_clr),
        .st_o  (st)
    );

    assign nmi_req = req & ~state_q.ctrl.redir & ~state_q.mask;

    always_comb begin
        state_d          = state_q;
        if (wr_ctrl) state_d.ctrl = ctrl_t'(wr_data_i[CTRL_W-1:0]);
        if (wr_mask) state_d.mask = wr_data_i[MASK_BIT];
        state_d.nmi      = nmi_req & ~state_q.nmi_prev;
        state_d.nmi_prev = nmi_req;
        state_d.smi      = req & state_q.ctrl.redir;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.mask <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == CTRL_ADDR)      rd_data_o[CTRL_W-1:0] = state_q.ctrl;
        else if (rd_addr_i == STAT_ADDR) rd_data_o[NUM_ST-1:0] = st;
        else if (rd_addr_i == MASK_ADDR) rd_data_o[MASK_BIT]   = state_q.mask;
    end

    assign nmi_o   = state_q.nmi;
    assign smi_o   = state_q.smi;
    assign mask_w  = state_q.mask;
    assign redir_w = state_q.ctrl.redir;
    assign stat_w  = st;

endmodule

// File: rtl/nmi_router_chk.sv
module nmi_router_chk #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 'h11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nmi_o,
    input logic              smi_o,
    input logic              mask_w,
    input logic              redir_w,
    input logic [4:0]        stat_w,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data
);
    AST_NMI_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |=> !nmi_o); // R8
    AST_MASK_BLOCKS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> !$past(mask_w)); // R2
    AST_REDIRECT_SILENCES_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> !$past(redir_w)); // R9
    AST_SMI_ONLY_REDIRECTED: assert property (@(posedge clk) disable iff (!rst_n)
        smi_o |-> $past(redir_w)); // R9
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_w[0]) |-> $past(wr_en && wr_addr == STAT_ADDR && wr_data[0])); // R7
    AST_SMI_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smi_o) |-> stat_w[4]); // R10
endmodule

bind nmi_router nmi_router_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .STAT_ADDR (STAT_ADDR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .nmi_o   (nmi_o),
    .smi_o   (smi_o),
    .mask_w  (mask_w),
    .redir_w (redir_w),
    .stat_w  (stat_w),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i)
);

// File: tb/nmi_router_bench.sv
module nmi_router_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'h10, A_STAT = 8'h11, A_SW = 8'h12, A_MASK = 8'h70;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       serr = 1'b0, iochk = 1'b0, pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0, rd_data;
    logic       nmi, smi;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 1'b0;

    // reference model state
    logic [2:0] m_en;
    logic       m_fall, m_redir, m_mask, m_s1, m_s2, m_s3, m_nmi, m_prev, m_smi;
    logic [4:0] m_st;

    always #(CLK_PERIOD/2) clk = ~clk;

    nmi_router u_nmi_router (
        .clk(clk), .rst_n(rst_n), .serr_i(serr), .iochk_i(iochk), .nmi_pin_i(pin),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .nmi_o(nmi), .smi_o(smi)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = '0; m_fall = 0; m_redir = 0; m_mask = 1; m_st = '0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_nmi = 0; m_prev = 0; m_smi = 0;
        end else begin
            logic req, nreq, edg;
            logic [4:0] set, clr;
            req  = (m_st[0] & m_en[0]) | (m_st[1] & m_en[1]) | (m_st[2] & m_en[2]) | m_st[3];
            nreq = req & !m_redir & !m_mask;
            edg  = m_fall ? (!m_s2 & m_s3) : (m_s2 & !m_s3);
            set  = {m_redir & req, wr_en && wr_addr == A_SW && wr_data[0], edg, iochk, serr};
            clr  = (wr_en && wr_addr == A_STAT) ? wr_data[4:0] : 5'd0;
            m_st = (m_st & ~clr) | set;
            m_nmi = nreq & !m_prev; m_prev = nreq; m_smi = req & m_redir;
            if (wr_en && wr_addr == A_CTRL) {m_redir, m_fall, m_en} = wr_data[4:0];
            if (wr_en && wr_addr == A_MASK) m_mask = wr_data[7];
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
        end
    end

    function automatic logic [7:0] exp_rd(logic [7:0] a);
        if (a == A_CTRL) return {3'b0, m_redir, m_fall, m_en};
        if (a == A_STAT) return {3'b0, m_st};
        if (a == A_MASK) return {m_mask, 7'b0};
        return 8'h00;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d; tick(); wr_en = 0;
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [7:0] exp);
        rd_addr = a; #1; chk(tag, rd_data, exp);
    endtask

    // continuous comparison of both outputs against the model
    always @(negedge clk) if (rst_n && !done) begin
        chk("R8 nmi_o vs model", {7'b0, nmi}, {7'b0, m_nmi});
        chk("R9 smi_o vs model", {7'b0, smi}, {7'b0, m_smi});
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1; fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) tick();
        rst_n = 1; tick();
        rd_chk("R1 mask reset", A_MASK, 8'h80);
        rd_chk("R1 status reset", A_STAT, 8'h00);
        rd_chk("R1 control reset", A_CTRL, 8'h00);
        chk("R1 nmi reset", {7'b0, nmi}, 8'h00);

        // R6 software trigger while masked
        wr(A_SW, 8'h01); tick(); tick();
        rd_chk("R6 sw status", A_STAT, 8'h08);
        rd_chk("R6 sw reg reads zero", A_SW, 8'h00);
        chk("R2 masked nmi", {7'b0, nmi}, 8'h00);
        // R2 unmask with other bits set
        wr(A_MASK, 8'h7F); tick();
        chk("R2 unmasked nmi", {7'b0, nmi}, 8'h01);
        rd_chk("R2 mask readback", A_MASK, 8'h00);
        tick(); chk("R8 pulse width", {7'b0, nmi}, 8'h00);
        // R7 write 0 keeps, write 1 clears
        wr(A_STAT, 8'h00); rd_chk("R7 write zero", A_STAT, 8'h08);
        wr(A_STAT, 8'h08); rd_chk("R7 w1c", A_STAT, 8'h00);

        // R3 system error, disabled then enabled
        serr = 1; tick(); serr = 0;
        rd_chk("R3 status set while disabled", A_STAT, 8'h01);
        tick(); tick(); chk("R3 no nmi while disabled", {7'b0, nmi}, 8'h00);
        wr(A_CTRL, 8'h01); tick();
        chk("R3 nmi after enable", {7'b0, nmi}, 8'h01);
        tick(); chk("R8 no refire while held", {7'b0, nmi}, 8'h00);
        tick(); chk("R8 still no refire", {7'b0, nmi}, 8'h00);
        wr(A_STAT, 8'h01);
        serr = 1; tick(); serr = 0; tick();
        chk("R8 refire after clear", {7'b0, nmi}, 8'h01);
        wr(A_STAT, 8'h01);

        // R4 I/O check
        wr(A_CTRL, 8'h02);
        iochk = 1; tick(); iochk = 0; tick();
        chk("R4 iochk nmi", {7'b0, nmi}, 8'h01);
        wr(A_STAT, 8'h02);

        // R5 pin, falling polarity
        wr(A_CTRL, 8'h0C);
        pin = 1; repeat (4) tick();
        rd_chk("R5 rising ignored", A_STAT, 8'h00);
        pin = 0; tick(); tick(); tick();
        rd_chk("R5 falling edge status", A_STAT, 8'h04);
        tick(); chk("R5 pin nmi", {7'b0, nmi}, 8'h01);
        wr(A_STAT, 8'h04);

        // R9 / R10 redirect
        wr(A_CTRL, 8'h11);
        serr = 1; tick(); serr = 0; tick();
        chk("R9 smi level", {7'b0, smi}, 8'h01);
        chk("R9 nmi silent", {7'b0, nmi}, 8'h00);
        rd_chk("R10 smi status", A_STAT, 8'h11);
        wr(A_STAT, 8'h01); tick();
        chk("R9 smi drops", {7'b0, smi}, 8'h00);
        rd_chk("R10 smi status sticky", A_STAT, 8'h10);
        wr(A_STAT, 8'h10); rd_chk("R10 smi status clear", A_STAT, 8'h00);
        wr(A_CTRL, 8'h00);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] addrs [5];
            addrs = '{A_CTRL, A_STAT, A_SW, A_MASK, 8'h33};
            wr_en   = ($urandom % 4) == 0;
            wr_addr = addrs[$urandom % 5];
            wr_data = 8'($urandom);
            serr    = ($urandom % 16) == 0;
            iochk   = ($urandom % 16) == 0;
            if (($urandom % 6) == 0) pin = ~pin;
            rd_addr = addrs[$urandom % 5];
            #1;
            chk(rd_addr == A_STAT ? "R7 status model" :
                rd_addr == A_MASK ? "R2 mask model" :
                rd_addr == A_CTRL ? "R5 control model" : "R6 other reads",
                rd_data, exp_rd(rd_addr));
            tick();
        end
        wr_en = 0; serr = 0; iochk = 0;
        tick();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule